// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog that counts a slow tick enable through a programmable divider and a 12-bit down-counter. Once armed, it requests a system reset whenever the counter runs out, unless software refreshes the counter in time. Software reaches it through four 32-bit word registers on a simple single-cycle bus. A key register accepts three command values: arm, refresh and unlock. A divider register and a reload register hold the configuration. A status register reports configuration changes that have not yet taken effect.

The divider and reload registers are write-protected. A write to either one is accepted only when the most recent key write was the unlock value. Any other key value closes access again. An accepted write goes into a pending copy first. The counting logic only uses it after a fixed number of prescaled ticks, and a status flag stays high for that whole wait. This models a value being carried into a slow counting domain without building a second clock. Once armed, the watchdog cannot be disarmed by software.

Top module: `kwdt_top`

## Requirements
- R1: After reset the divider register reads 0, the reload register reads 0xFFF, the status register reads 0, and no reset request is made while the watchdog has not been armed.
- R2: The key register sits at byte offset 0x0 and always reads 0. Only bits 15:0 of a key write are compared; bits 31:16 are ignored.
- R3: Writes to the divider (offset 0x4) or reload (offset 0x8) register change nothing unless the last key write was 0x5555. A key write of any other value removes that access.
- R4: A key write of 0xCCCC arms the watchdog and loads the counter from the active reload value. After that, no key write disarms it.
- R5: On a prescaled tick with the counter at 1 (or at 0), `wdt_rst_req` goes high for exactly one cycle and the counter reloads. With a steady tick enable, pulses repeat every reload×ratio cycles, or every ratio cycles for a reload of 0.
- R6: A key write of 0xAAAA reloads the counter from the active reload value, which postpones the next reset request.
- R7: Divider code c in bits 2:0 gives a ratio of 4·2^c for c = 0..6, and code 7 also gives 256. The register reads back the code that was written.
- R8: Reload bits 11:0 are kept and higher bits read as 0. Divider bits 31:3 read as 0.
- R9: The status register is at offset 0xC. Bit 0 is high while a divider update is pending and bit 1 is high while a reload update is pending. Each bit rises in the cycle after the accepted write and falls after 5 prescaled ticks at the ratio in use.
- R10: A pending value has no effect until its status bit falls. Until then the counter and the divider keep using the old value.
- R11: A new accepted write while an update is still pending replaces the pending value and restarts the 5-tick wait.
- R12: The divider advances only in cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow tick enable that feeds the divider |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| wdt_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong lock bit shows up on the very next readback of the divider or reload register, because a blocked write leaves the old value and the status bits at zero. A wrong pending-wait count moves the fall of a status bit by one prescaled tick, which is 4 to 256 cycles depending on the ratio. An active value applied too early or too late changes the spacing of `wdt_rst_req` pulses within one expiry period. A counter that drifts or misses a refresh produces a pulse outside the window of one prescaled tick that the bench computes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    // word select from address bits 3:2
    typedef enum logic [1:0] {
        SEL_KEY = 2'd0,
        SEL_PSC = 2'd1,
        SEL_RLD = 2'd2,
        SEL_STS = 2'd3
    } wreg_e;

    localparam int          KEY_W    = 16;
    localparam logic [15:0] KEY_ARM  = 16'hCCCC;
    localparam logic [15:0] KEY_FEED = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN = 16'h5555;

endpackage

// File: rtl/kwdt_sync_slot.sv
// Pending/active pair for one configuration value; the pending copy
// becomes active after SYNC_TICKS prescaled ticks.
module kwdt_sync_slot #(
    parameter int             W          = 12,
    parameter int             SYNC_TICKS = 5,
    parameter logic [W-1:0]   INIT       = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_val,
    input  logic         ptick,
    output logic [W-1:0] pend,
    output logic [W-1:0] act,
    output logic         busy
);

    localparam int             CW        = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0]  WAIT_INIT = CW'(SYNC_TICKS);
    localparam logic [CW-1:0]  WAIT_LAST = CW'(1);

    typedef struct packed {
        logic [W-1:0]  pend;
        logic [W-1:0]  act;
        logic [CW-1:0] wait_cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_stb) begin
            s_d.pend     = wr_val;
            s_d.wait_cnt = WAIT_INIT;
        end else if (ptick && (s_q.wait_cnt != '0)) begin
            s_d.wait_cnt = s_q.wait_cnt - 1'b1;
            if (s_q.wait_cnt == WAIT_LAST) begin
                s_d.act = s_q.pend;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pend     <= INIT;
            s_q.act      <= INIT;
            s_q.wait_cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend = s_q.pend;
    assign act  = s_q.act;
    assign busy = (s_q.wait_cnt != '0);

endmodule

// File: rtl/kwdt_prescaler.sv
// Divides tick_en by 4 * 2^code, saturating at the largest ratio.
module kwdt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [PSC_W-1:0] code,
    output logic             ptick
);

    localparam int                MAXC   = (1 << PSC_W) - 2;
    localparam int                PDIV_W = MAXC + 2;
    localparam logic [PSC_W-1:0]  MAXC_V = PSC_W'(MAXC);

    logic [PSC_W-1:0]  shamt;
    logic [PDIV_W-1:0] limit;
    logic [PDIV_W-1:0] cnt_d, cnt_q;
    logic              wrap;

    always_comb begin
        shamt = (code > MAXC_V) ? MAXC_V : code;
        // all ones shifted down gives ratio - 1
        limit = {PDIV_W{1'b1}} >> (MAXC_V - shamt);
        wrap  = (cnt_q >= limit);
        ptick = tick_en && wrap;
        cnt_d = cnt_q;
        if (tick_en) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/kwdt_counter.sv
// Armed down-counter with refresh and one-cycle expiry pulse.
module kwdt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_stb,
    input  logic             feed_stb,
    input  logic             ptick,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic             fire;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.fire = 1'b0;
        if (!c_q.run) begin
            if (arm_stb) begin
                c_d.run = 1'b1;
                c_d.cnt = reload;
            end
        end else if (feed_stb) begin
            c_d.cnt = reload;
        end else if (ptick) begin
            if (c_q.cnt <= ONE) begin
                c_d.cnt  = reload;
                c_d.fire = 1'b1;
            end else begin
                c_d.cnt = c_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.run  <= 1'b0;
            c_q.cnt  <= '1;
            c_q.fire <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign running = c_q.run;
    assign count   = c_q.cnt;
    assign expire  = c_q.fire;

endmodule

// File: rtl/kwdt_regs.sv
// Word decode, key commands, write lock and the two update slots.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 12,
    parameter int PSC_W      = 3,
    parameter int SYNC_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ptick,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PSC_W-1:0]  psc_pend,
    output logic [PSC_W-1:0]  psc_act,
    output logic              psc_busy,
    output logic [CNT_W-1:0]  rld_pend,
    output logic [CNT_W-1:0]  rld_act,
    output logic              rld_busy,
    output logic              arm_stb,
    output logic              feed_stb,
    output logic              unlocked
);

    wreg_e             sel;
    logic              wr;
    logic              key_wr;
    logic [KEY_W-1:0]  key;
    logic              psc_stb;
    logic              rld_stb;
    logic              open_d, open_q;
    logic              unused_bits;

    always_comb begin
        sel      = wreg_e'(bus_addr[3:2]);
        wr       = bus_sel && bus_wr;
        key      = bus_wdata[KEY_W-1:0];
        key_wr   = wr && (sel == SEL_KEY);
        arm_stb  = key_wr && (key == KEY_ARM);
        feed_stb = key_wr && (key == KEY_FEED);
        psc_stb  = wr && (sel == SEL_PSC) && open_q;
        rld_stb  = wr && (sel == SEL_RLD) && open_q;
        open_d   = open_q;
        if (key_wr) begin
            open_d = (key == KEY_OPEN);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end

    assign unlocked    = open_q;
    assign unused_bits = ^{bus_addr, bus_wdata};

    kwdt_sync_slot #(
        .W          (PSC_W),
        .SYNC_TICKS (SYNC_TICKS),
        .INIT       ('0)
    ) i_psc_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (psc_stb),
        .wr_val (bus_wdata[PSC_W-1:0]),
        .ptick  (ptick),
        .pend   (psc_pend),
        .act    (psc_act),
        .busy   (psc_busy)
    );

    kwdt_sync_slot #(
        .W          (CNT_W),
        .SYNC_TICKS (SYNC_TICKS),
        .INIT       ('1)
    ) i_rld_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (rld_stb),
        .wr_val (bus_wdata[CNT_W-1:0]),
        .ptick  (ptick),
        .pend   (rld_pend),
        .act    (rld_act),
        .busy   (rld_busy)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_PSC: bus_rdata[PSC_W-1:0] = psc_pend;
            SEL_RLD: bus_rdata[CNT_W-1:0] = rld_pend;
            SEL_STS: bus_rdata[1:0]       = {rld_busy, psc_busy};
            default: bus_rdata            = '0;
        endcase
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 12,
    parameter int PSC_W      = 3,
    parameter int SYNC_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_req
);

    logic [PSC_W-1:0] psc_pend_w, psc_act_w;
    logic [CNT_W-1:0] rld_pend_w, rld_act_w;
    logic             psc_busy_w, rld_busy_w;
    logic             arm_w, feed_w, unlock_w;
    logic             ptick_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;

    kwdt_regs #(
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .PSC_W      (PSC_W),
        .SYNC_TICKS (SYNC_TICKS)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ptick     (ptick_w),
        .bus_rdata (bus_rdata),
        .psc_pend  (psc_pend_w),
        .psc_act   (psc_act_w),
        .psc_busy  (psc_busy_w),
        .rld_pend  (rld_pend_w),
        .rld_act   (rld_act_w),
        .rld_busy  (rld_busy_w),
        .arm_stb   (arm_w),
        .feed_stb  (feed_w),
        .unlocked  (unlock_w)
    );

    kwdt_prescaler #(
        .PSC_W (PSC_W)
    ) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .code    (psc_act_w),
        .ptick   (ptick_w)
    );

    kwdt_counter #(
        .CNT_W (CNT_W)
    ) i_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_stb  (arm_w),
        .feed_stb (feed_w),
        .ptick    (ptick_w),
        .reload   (rld_act_w),
        .running  (run_w),
        .count    (cnt_w),
        .expire   (wdt_rst_req)
    );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 12,
    parameter int PSC_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdt_rst_req,
    input logic              running,
    input logic              unlocked,
    input logic              ptick,
    input logic              feed,
    input logic [CNT_W-1:0]  count,
    input logic [PSC_W-1:0]  psc_pend,
    input logic [PSC_W-1:0]  psc_act,
    input logic              psc_busy,
    input logic [CNT_W-1:0]  rld_pend,
    input logic [CNT_W-1:0]  rld_act,
    input logic              rld_busy
);

    logic psc_try, rld_try;
    assign psc_try = bus_sel && bus_wr && (bus_addr[3:2] == 2'd1);
    assign rld_try = bus_sel && bus_wr && (bus_addr[3:2] == 2'd2);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !wdt_rst_req);

    assert_stays_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req);

    assert_locked_psc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_try && !unlocked) |=> $stable(psc_pend) && !$rose(psc_busy));

    assert_locked_rld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_try && !unlocked) |=> $stable(rld_pend) && !$rose(rld_busy));

    assert_count_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !ptick && !feed) |=> $stable(count));

    assert_psc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !psc_busy |=> $stable(psc_act));

    assert_rld_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rld_busy |=> $stable(rld_act));

    assert_psc_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psc_busy) |-> (psc_act == psc_pend));

    assert_rld_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rld_busy) |-> (rld_act == rld_pend));

endmodule

bind kwdt_top kwdt_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .PSC_W  (PSC_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wdt_rst_req (wdt_rst_req),
    .running     (run_w),
    .unlocked    (unlock_w),
    .ptick       (ptick_w),
    .feed        (feed_w),
    .count       (cnt_w),
    .psc_pend    (psc_pend_w),
    .psc_act     (psc_act_w),
    .psc_busy    (psc_busy_w),
    .rld_pend    (rld_pend_w),
    .rld_act     (rld_act_w),
    .rld_busy    (rld_busy_w)
);

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;

    localparam int A_KEY = 4'h0;
    localparam int A_PSC = 4'h4;
    localparam int A_RLD = 4'h8;
    localparam int A_STS = 4'hC;
    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        gate_mode = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) tick_en <= gate_mode ? ~tick_en : 1'b1;

    kwdt_top i_kwdt_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // called at a negedge, returns at the negedge after the write edge
    task automatic wr(input int addr, input int data);
        bus_addr  = 4'(addr);
        bus_wdata = 32'(data);
        bus_sel   = 1'b1;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        bus_addr = 4'(addr);
        bus_sel  = 1'b1;
        #1;
        data    = int'(bus_rdata);
        bus_sel = 1'b0;
    endtask

    // negedges until the status register reads 0
    task automatic wait_idle(output int n);
        int v;
        n = 0;
        v = 1;
        while (v != 0 && n < LIMIT) begin
            @(negedge clk);
            n++;
            rd(A_STS, v);
        end
    endtask

    // negedges until a reset request is seen
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wdt_rst_req && n < LIMIT);
    endtask

    // from a pulse negedge: check width, return spacing to the next pulse
    task automatic interval(input string req, output int n);
        int m;
        @(negedge clk);
        chk({req, " pulse width"}, int'(wdt_rst_req), 0);
        wait_pulse(m);
        n = m + 1;
    endtask

    task automatic t_reset;
        int v, pulses;
        rd(A_PSC, v); chk("R1 divider reset", v, 0);
        rd(A_RLD, v); chk("R1 reload reset", v, 'hFFF);
        rd(A_STS, v); chk("R1 status reset", v, 0);
        rd(A_KEY, v); chk("R2 key reads zero", v, 0);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (wdt_rst_req) pulses++;
        end
        chk("R1 no request before arming", pulses, 0);
    endtask

    task automatic t_lock;
        int v;
        wr(A_PSC, 3);
        rd(A_PSC, v); chk("R3 locked divider write", v, 0);
        rd(A_STS, v); chk("R3 locked status", v, 0);
        wr(A_KEY, 'h5555);
        wr(A_KEY, 'h1234);
        wr(A_RLD, 5);
        rd(A_RLD, v); chk("R3 relocked reload write", v, 'hFFF);
    endtask

    task automatic t_config;
        int v, n;
        wr(A_KEY, 'h5555);
        wr(A_RLD, 'hFFFFF008);
        rd(A_RLD, v); chk("R8 reload upper bits", v, 'h008);
        rd(A_STS, v); chk("R9 reload busy bit", v, 2);
        wr(A_PSC, 'hFFFFFFF8);
        rd(A_PSC, v); chk("R8 divider upper bits", v, 0);
        rd(A_STS, v); chk("R9 both busy bits", v, 3);
        wait_idle(n); chk_rng("R9 busy duration", n, 14, 20);
        wr(A_RLD, 6);
        repeat (8) @(negedge clk);
        wr(A_RLD, 4);
        wait_idle(n); chk_rng("R11 wait restarts", n, 17, 20);
        rd(A_RLD, v); chk("R11 latest value kept", v, 4);
    endtask

    task automatic t_arm;
        int n, v;
        wr(A_KEY, 'hABCDCCCC);
        wait_pulse(n); chk_rng("R4 first expiry (R2 upper key bits)", n, 13, 16);
        interval("R5", n); chk("R5 expiry spacing", n, 16);
        rd(A_KEY, v); chk("R2 key reads zero armed", v, 0);
        wr(A_KEY, 'h0000);
        wr(A_KEY, 'h5555);
        wr(A_KEY, 'hCCCC);
        wait_pulse(n); chk_rng("R4 cannot disarm", n, 1, 16);
    endtask

    task automatic t_feed;
        int n, pulses;
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            wr(A_KEY, 'hAAAA);
            for (int j = 0; j < 7; j++) begin
                @(negedge clk);
                if (wdt_rst_req) pulses++;
            end
        end
        chk("R6 refresh holds off expiry", pulses, 0);
        wr(A_KEY, 'hAAAA);
        wait_pulse(n); chk_rng("R6 expiry after refresh", n, 13, 16);
    endtask

    task automatic t_pending;
        int n;
        wr(A_KEY, 'h5555);
        wr(A_RLD, 8);
        wr(A_KEY, 'hAAAA);
        wait_pulse(n); chk_rng("R10 old reload still used", n, 13, 16);
        repeat (48) @(negedge clk);
        wait_pulse(n);
        interval("R10", n); chk("R10 new reload after apply", n, 32);
    endtask

    task automatic t_ratio;
        int n, v;
        int codes[5] = '{0, 1, 5, 6, 7};
        wr(A_KEY, 'h5555);
        wr(A_RLD, 1);
        wait_idle(n);
        for (int k = 0; k < 5; k++) begin
            int c, exp;
            c = codes[k];
            exp = 4 << ((c > 6) ? 6 : c);
            wr(A_KEY, 'h5555);
            wr(A_PSC, c);
            rd(A_PSC, v); chk("R7 divider readback", v, c);
            wait_idle(n);
            wait_pulse(n);
            interval("R7", n); chk($sformatf("R7 ratio code %0d", c), n, exp);
        end
        wr(A_KEY, 'h5555);
        wr(A_PSC, 0);
        wait_idle(n);
        wr(A_KEY, 'h5555);
        wr(A_RLD, 0);
        wait_idle(n);
        wait_pulse(n);
        interval("R5", n); chk("R5 reload zero spacing", n, 4);
    endtask

    task automatic t_gate;
        int n;
        gate_mode = 1'b1;
        wait_pulse(n);
        wait_pulse(n);
        interval("R12", n); chk("R12 half-rate tick spacing", n, 8);
        gate_mode = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock();
        t_config();
        t_arm();
        t_feed();
        t_pending();
        t_ratio();
        t_gate();
        summary();
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule